// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block drives the external bus of several static memory or memory-mapped peripheral banks on behalf of one host. The host presents a bank number, an offset inside that bank, a write flag and write data, and holds a request high. The block then runs the external strobe sequence for that bank. It drives the address, drops the bank's active-low chip select, drops output enable (read) or write enable (write), releases the strobes in reverse order and pulses an acknowledge. On a read, the sampled data is returned with the acknowledge.

Every bank has its own set of six cycle counts: address setup before chip select, chip-select setup before the strobe, access length, chip-select hold after the strobe, address hold after chip select, and page-beat length. Each bank also has a data width (one or two bytes) and a page-mode flag. With page mode set, a read keeps the strobes low over four consecutive beats and returns four words. Settings are taken from per-bank configuration inputs when the request is accepted.

Top module: `smc_sequencer`

## Requirements
- R1: While reset is held and after it is released, every chip select, output enable and write enable is high (inactive), ack is 0, the write-data enable is 0 and rd_data is all zero.
- R2: During a transfer only ext_csn[req_bank] goes low; every other chip-select bit stays high.
- R3: Counting the first cycle after acceptance as cycle 0, the selected chip select first goes low in cycle t_asu (4-bit, 0..15). A value of 0 means it is low in cycle 0.
- R4: The strobe (ext_oen for a read, ext_wen for a write) first goes low t_csu cycles (4-bit, 0..15) after chip select goes low. A value of 0 drops both in the same cycle.
- R5: On a single access the strobe stays low for exactly t_acc+1 consecutive cycles, where t_acc is 5-bit (0..31).
- R6: Chip select rises t_csh cycles after the strobe rises. ack is high t_ah cycles after chip select rises, and only for one cycle; both values are 4-bit, 0..15.
- R7: A single read returns its datum in rd_data[15:0] and zeros in the other words. Width bit 1 selects 2 bytes, so all 16 data lines are taken. Width bit 0 selects 1 byte, so only ext_din[7:0] is taken and bits 15:8 read as 0.
- R8: A read with page bit 1 keeps chip select and output enable low for (t_acc+1) + 3*max(t_pg,1) cycles. It returns four words, word k in rd_data[16k+15:16k], read from address offset + k*width, taken modulo 256.
- R9: A write drives ext_wen and never ext_oen, and ignores the page bit. ext_dout_en is high from the start of the chip-select setup phase to the end of the address hold phase. ext_dout equals req_wdata, or {8'h00, req_wdata[7:0]} when the width is 1 byte.
- R10: Changes to the bank's configuration or to the request fields after a request is accepted do not alter the running transfer.
- R11: A request is accepted only while the block is idle. In the ack cycle all strobes are already high, and ack is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until ack |
| req_bank | input | 2 | Target bank |
| req_offs | input | 8 | Offset inside the bank |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Read words, word k at bits 16k+15:16k |
| cfg_asu | input | 16 | Per-bank address setup, 4 bits per bank |
| cfg_csu | input | 16 | Per-bank chip-select setup, 4 bits per bank |
| cfg_acc | input | 20 | Per-bank access length minus one, 5 bits per bank |
| cfg_csh | input | 16 | Per-bank chip-select hold, 4 bits per bank |
| cfg_ah | input | 16 | Per-bank address hold, 4 bits per bank |
| cfg_pg | input | 16 | Per-bank page-beat length, 4 bits per bank |
| cfg_wide | input | 4 | Per-bank width, 1 = two bytes |
| cfg_page | input | 4 | Per-bank page mode, 1 = four-beat reads |
| ext_csn | output | 4 | Active-low chip select, one per bank |
| ext_oen | output | 1 | Active-low output enable |
| ext_wen | output | 1 | Active-low write enable |
| ext_addr | output | 8 | External address, 0 when idle |
| ext_dout | output | 16 | External write data |
| ext_dout_en | output | 1 | Write-data drive enable |
| ext_din | input | 16 | External read data |

## Verification
A wrong phase state or timer value shows up in the same transfer as a chip-select or strobe edge at the wrong cycle index, or as an ack at the wrong time. The bench therefore measures the edge positions against sums of the programmed counts. A wrong page-beat counter or address step reaches the ports as a wrong address. The bench's memory model turns each address into a distinct pattern, so the error becomes a wrong word in rd_data at that ack. A capture fault is exposed because every transfer scrambles its bank settings and request fields one cycle after acceptance.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int SHORT_W = 4;
  localparam int LONG_W  = 5;
  localparam int LEN_W   = LONG_W + 1;

  typedef struct packed {
    logic [SHORT_W-1:0] t_asu;
    logic [SHORT_W-1:0] t_csu;
    logic [LONG_W-1:0]  t_acc;
    logic [SHORT_W-1:0] t_csh;
    logic [SHORT_W-1:0] t_ah;
    logic [SHORT_W-1:0] t_pg;
    logic               wide;
    logic               page;
  } bank_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASU  = 3'd1,
    PH_CSU  = 3'd2,
    PH_ACC  = 3'd3,
    PH_PAGE = 3'd4,
    PH_CSH  = 3'd5,
    PH_AH   = 3'd6,
    PH_ACK  = 3'd7
  } phase_e;
endpackage

// File: rtl/smc_cfg_select.sv
module smc_cfg_select #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [BANK_W-1:0]                     bank_i,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] asu_i,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] csu_i,
  input  logic [NUM_BANKS*smc_pkg::LONG_W-1:0]  acc_i,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] csh_i,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] ah_i,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] pg_i,
  input  logic [NUM_BANKS-1:0]                  wide_i,
  input  logic [NUM_BANKS-1:0]                  page_i,
  output smc_pkg::bank_cfg_t                    cfg_o
);
  localparam int SW = smc_pkg::SHORT_W;
  localparam int LW = smc_pkg::LONG_W;

  smc_pkg::bank_cfg_t tbl [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign tbl[g].t_asu = asu_i[g*SW +: SW];
    assign tbl[g].t_csu = csu_i[g*SW +: SW];
    assign tbl[g].t_acc = acc_i[g*LW +: LW];
    assign tbl[g].t_csh = csh_i[g*SW +: SW];
    assign tbl[g].t_ah  = ah_i[g*SW +: SW];
    assign tbl[g].t_pg  = pg_i[g*SW +: SW];
    assign tbl[g].wide  = wide_i[g];
    assign tbl[g].page  = page_i[g];
  end

  assign cfg_o = tbl[bank_i];
endmodule

// File: rtl/smc_phase_timer.sv
module smc_phase_timer #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = len_i - LEN_W'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/smc_datapath.sv
module smc_datapath #(
  parameter int OFFS_W = 8,
  parameter int DATA_W = 16,
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept_i,
  input  logic [OFFS_W-1:0]       offs_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    wide_i,
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic                    addr_act_i,
  input  logic                    capture_i,
  input  logic [DATA_W-1:0]       din_i,
  output logic [OFFS_W-1:0]       addr_o,
  output logic [DATA_W-1:0]       dout_o,
  output logic [BEATS*DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  logic [OFFS_W-1:0] offs_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFFS_W-1:0] step;
  logic [DATA_W-1:0] din_fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      offs_q  <= offs_i;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    step    = wide_i ? OFFS_W'({beat_i, 1'b0}) : OFFS_W'(beat_i);
    addr_o  = addr_act_i ? (offs_q + step) : '0;
    dout_o  = wide_i ? wdata_q : {{(DATA_W-HALF){1'b0}}, wdata_q[HALF-1:0]};
    din_fmt = wide_i ? din_i : {{(DATA_W-HALF){1'b0}}, din_i[HALF-1:0]};
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;

    always_comb begin
      word_d = word_q;
      if (accept_i) begin
        word_d = '0;
      end else if (capture_i && (beat_i == BEAT_W'(g))) begin
        word_d = din_fmt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else begin
        word_q <= word_d;
      end
    end

    assign rdata_o[g*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/smc_sequencer.sv
module smc_sequencer #(
  parameter int NUM_BANKS = 4,
  parameter int OFFS_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BEATS     = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req,
  input  logic [$clog2(NUM_BANKS)-1:0]          req_bank,
  input  logic [OFFS_W-1:0]                     req_offs,
  input  logic                                  req_wr,
  input  logic [DATA_W-1:0]                     req_wdata,
  output logic                                  ack,
  output logic [BEATS*DATA_W-1:0]               rd_data,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] cfg_asu,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] cfg_csu,
  input  logic [NUM_BANKS*smc_pkg::LONG_W-1:0]  cfg_acc,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] cfg_csh,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] cfg_ah,
  input  logic [NUM_BANKS*smc_pkg::SHORT_W-1:0] cfg_pg,
  input  logic [NUM_BANKS-1:0]                  cfg_wide,
  input  logic [NUM_BANKS-1:0]                  cfg_page,
  output logic [NUM_BANKS-1:0]                  ext_csn,
  output logic                                  ext_oen,
  output logic                                  ext_wen,
  output logic [OFFS_W-1:0]                     ext_addr,
  output logic [DATA_W-1:0]                     ext_dout,
  output logic                                  ext_dout_en,
  input  logic [DATA_W-1:0]                     ext_din
);
  import smc_pkg::*;

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int LW     = smc_pkg::LEN_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  phase_e            state_q, state_d, nxt;
  logic [BEAT_W-1:0] beat_q, beat_d;
  bank_cfg_t         cfg_sel, cfg_q, cfg_src;
  logic              wr_q, wr_src;
  logic [BANK_W-1:0] bank_q;
  logic [LW-1:0]     len [8];
  logic              accept, load, done, beat_end;
  logic [LW-1:0]     tmr_len;
  logic              cs_act, strobe_act, addr_act;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  smc_cfg_select #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_sel (
    .bank_i (req_bank),
    .asu_i  (cfg_asu),
    .csu_i  (cfg_csu),
    .acc_i  (cfg_acc),
    .csh_i  (cfg_csh),
    .ah_i   (cfg_ah),
    .pg_i   (cfg_pg),
    .wide_i (cfg_wide),
    .page_i (cfg_page),
    .cfg_o  (cfg_sel)
  );

  // Phase lengths; the idle phase looks at the incoming request.
  always_comb begin
    cfg_src = (state_q == PH_IDLE) ? cfg_sel : cfg_q;
    wr_src  = (state_q == PH_IDLE) ? req_wr  : wr_q;
    len[0]  = '0;
    len[1]  = LW'(cfg_src.t_asu);
    len[2]  = LW'(cfg_src.t_csu);
    len[3]  = LW'(cfg_src.t_acc) + LW'(1);
    len[4]  = (cfg_src.page && !wr_src) ?
              ((cfg_src.t_pg == '0) ? LW'(1) : LW'(cfg_src.t_pg)) : '0;
    len[5]  = LW'(cfg_src.t_csh);
    len[6]  = LW'(cfg_src.t_ah);
    len[7]  = LW'(1);
    nxt     = PH_ACK;
    for (int i = 7; i >= 1; i--) begin
      if ((i > int'(state_q)) && (len[i] != '0)) begin
        nxt = phase_e'(3'(i));
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    accept   = 1'b0;
    load     = 1'b0;
    beat_end = 1'b0;
    tmr_len  = len[int'(nxt)];
    case (state_q)
      PH_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          load    = 1'b1;
          state_d = nxt;
          beat_d  = '0;
        end
      end
      PH_ACK: begin
        state_d = PH_IDLE;
      end
      default: begin
        if (done) begin
          beat_end = (state_q == PH_ACC) || (state_q == PH_PAGE);
          load     = 1'b1;
          if ((state_q == PH_PAGE) && (beat_q != BEAT_W'(BEATS-1))) begin
            tmr_len = len[int'(PH_PAGE)];
            beat_d  = beat_q + BEAT_W'(1);
          end else begin
            state_d = nxt;
            if ((state_q == PH_ACC) && (nxt == PH_PAGE)) begin
              beat_d = beat_q + BEAT_W'(1);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PH_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q  <= '0;
      wr_q   <= 1'b0;
      bank_q <= '0;
    end else if (accept) begin
      cfg_q  <= cfg_sel;
      wr_q   <= req_wr;
      bank_q <= req_bank;
    end
  end

  smc_phase_timer #(.LEN_W(LW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .len_i  (tmr_len),
    .done_o (done)
  );

  assign cs_act     = (state_q == PH_CSU) || (state_q == PH_ACC) ||
                      (state_q == PH_PAGE) || (state_q == PH_CSH);
  assign strobe_act = (state_q == PH_ACC) || (state_q == PH_PAGE);
  assign addr_act   = (state_q != PH_IDLE) && (state_q != PH_ACK);

  smc_datapath #(
    .OFFS_W(OFFS_W), .DATA_W(DATA_W), .BEATS(BEATS), .BEAT_W(BEAT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept_i   (accept),
    .offs_i     (req_offs),
    .wdata_i    (req_wdata),
    .wide_i     (cfg_q.wide),
    .beat_i     (beat_q),
    .addr_act_i (addr_act),
    .capture_i  (beat_end && !wr_q),
    .din_i      (ext_din),
    .addr_o     (ext_addr),
    .dout_o     (ext_dout),
    .rdata_o    (rd_data)
  );

  always_comb begin
    ext_csn = '1;
    if (cs_act) begin
      ext_csn[bank_q] = 1'b0;
    end
  end

  assign ext_oen     = !(strobe_act && !wr_q);
  assign ext_wen     = !(strobe_act && wr_q);
  assign ext_dout_en = wr_q && addr_act && (state_q != PH_ASU);
  assign ack         = (state_q == PH_ACK);
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int NUM_BANKS = 4,
  parameter int OFFS_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack,
  input logic [NUM_BANKS-1:0] ext_csn,
  input logic                 ext_oen,
  input logic                 ext_wen,
  input logic [OFFS_W-1:0]    ext_addr,
  input logic                 ext_dout_en
);
  a_r2_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_csn));

  a_r4_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_oen || !ext_wen) |-> !(&ext_csn));

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_oen && !ext_wen));

  a_r9_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_oen |-> !ext_dout_en);

  a_r9_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wen |-> ext_dout_en);

  a_r9_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_wen && $past(!ext_wen)) |-> $stable(ext_addr));

  a_r8_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_oen && $past(!ext_oen)) |-> $stable(ext_csn));

  a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r11_idle_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ((&ext_csn) && ext_oen && ext_wen));
endmodule

bind smc_sequencer smc_checker #(.NUM_BANKS(NUM_BANKS), .OFFS_W(OFFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack         (ack),
  .ext_csn     (ext_csn),
  .ext_oen     (ext_oen),
  .ext_wen     (ext_wen),
  .ext_addr    (ext_addr),
  .ext_dout_en (ext_dout_en)
);

// File: tb/sim_smc_sequencer.sv
module sim_smc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_offs = '0;
  logic        req_wr = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        ack;
  logic [63:0] rd_data;
  logic [15:0] c_asu = '0, c_csu = '0, c_csh = '0, c_ah = '0, c_pg = '0;
  logic [19:0] c_acc = '0;
  logic [3:0]  c_wide = '0, c_page = '0;
  logic [3:0]  ext_csn;
  logic        ext_oen, ext_wen, ext_dout_en;
  logic [7:0]  ext_addr;
  logic [15:0] ext_dout, ext_din;

  int nchk = 0;
  int nfail = 0;
  int ntr = 0;

  always #5 clk = ~clk;

  // Memory model: each address yields a distinct two-byte pattern.
  assign ext_din = {~ext_addr, ext_addr ^ 8'h3C};

  smc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_bank(req_bank),
    .req_offs(req_offs), .req_wr(req_wr), .req_wdata(req_wdata),
    .ack(ack), .rd_data(rd_data),
    .cfg_asu(c_asu), .cfg_csu(c_csu), .cfg_acc(c_acc), .cfg_csh(c_csh),
    .cfg_ah(c_ah), .cfg_pg(c_pg), .cfg_wide(c_wide), .cfg_page(c_page),
    .ext_csn(ext_csn), .ext_oen(ext_oen), .ext_wen(ext_wen),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_dout_en(ext_dout_en),
    .ext_din(ext_din)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h (transfer %0d)", tag, act, exp, ntr);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [7:0] a, input bit wide);
    return wide ? {~a, a ^ 8'h3C} : {8'h00, a ^ 8'h3C};
  endfunction

  task automatic set_bank(input int b, input int asu, input int csu, input int acc,
                          input int csh, input int ah, input int pg,
                          input bit wide, input bit page);
    c_asu[b*4 +: 4] = 4'(asu);
    c_csu[b*4 +: 4] = 4'(csu);
    c_acc[b*5 +: 5] = 5'(acc);
    c_csh[b*4 +: 4] = 4'(csh);
    c_ah[b*4 +: 4]  = 4'(ah);
    c_pg[b*4 +: 4]  = 4'(pg);
    c_wide[b]       = wide;
    c_page[b]       = page;
  endtask

  task automatic run(input int b, input logic [7:0] offs, input bit wr,
                     input logic [15:0] wd, input int asu, input int csu,
                     input int acc, input int csh, input int ah, input int pg,
                     input bit wide, input bit page);
    int  first_cs = -1, last_cs = -1, first_st = -1, last_st = -1, n_st = 0;
    int  i_ack = -1, n_den = 0, idx = 0;
    bit  other_bad = 0, wrong_strobe = 0, dout_bad = 0;
    logic [15:0] exp_d, bad_d;
    logic [63:0] exp_rd;
    int  pgl, alen, exp_den;
    set_bank(b, asu, csu, acc, csh, ah, pg, wide, page);
    @(negedge clk);
    req = 1'b1; req_bank = 2'(b); req_offs = offs; req_wr = wr; req_wdata = wd;
    exp_d = wide ? wd : {8'h00, wd[7:0]};
    bad_d = '0;
    while (i_ack < 0 && idx < 300) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (k != b && !ext_csn[k]) other_bad = 1;
      end
      if (!ext_csn[b]) begin
        if (first_cs < 0) first_cs = idx;
        last_cs = idx;
      end
      if (ext_dout_en) n_den++;
      if ((wr ? ext_oen : ext_wen) == 1'b0) wrong_strobe = 1;
      if ((wr ? ext_wen : ext_oen) == 1'b0) begin
        if (first_st < 0) first_st = idx;
        last_st = idx;
        n_st++;
        if (wr && (!ext_dout_en || ext_dout != exp_d)) begin
          dout_bad = 1; bad_d = ext_dout;
        end
      end
      if (idx == 0) begin
        // scramble settings and request fields while the transfer runs (R10)
        set_bank(b, asu ^ 5, csu ^ 3, acc ^ 7, csh ^ 6, ah ^ 9, pg ^ 4, !wide, !page);
        req_offs = ~offs; req_wr = !wr; req_wdata = ~wd; req_bank = 2'(b + 1);
      end
      if (ack) i_ack = idx;
      idx++;
    end
    req = 1'b0;
    pgl  = (page && !wr) ? 3 * ((pg == 0) ? 1 : pg) : 0;
    alen = acc + 1 + pgl;
    chk(i_ack >= 0, "R11 ack seen before timeout", 64'(i_ack), 64'(0));
    chk(!other_bad, "R2 other chip selects stay high", 64'(other_bad), 64'(0));
    chk(first_cs == asu, "R3 chip select fall cycle", 64'(first_cs), 64'(asu));
    chk(!wrong_strobe && first_st == asu + csu, "R4 strobe fall cycle",
        64'(first_st), 64'(asu + csu));
    chk(n_st == alen && last_st - first_st + 1 == alen,
        (page && !wr) ? "R8 page strobe length" : "R5 strobe length",
        64'(n_st), 64'(alen));
    chk(last_cs == last_st + csh && i_ack == last_cs + ah + 1,
        "R6 R10 chip select rise and ack cycle", 64'(i_ack),
        64'(asu + csu + alen + csh + ah));
    if (wr) begin
      exp_den = csu + acc + 1 + csh + ah;
      chk(!dout_bad, "R9 write data on bus", 64'(bad_d), 64'(exp_d));
      chk(n_den == exp_den, "R9 write drive window", 64'(n_den), 64'(exp_den));
    end else begin
      exp_rd = '0;
      for (int k = 0; k < ((page) ? 4 : 1); k++) begin
        exp_rd[k*16 +: 16] = exp_word(8'(offs + 8'(k * (wide ? 2 : 1))), wide);
      end
      chk(rd_data == exp_rd, page ? "R8 page read words" : "R7 single read data",
          rd_data, exp_rd);
      chk(n_den == 0, "R9 no drive on read", 64'(n_den), 64'(0));
    end
    set_bank(b, asu, csu, acc, csh, ah, pg, wide, page);
    @(negedge clk);
    chk(!ack && (&ext_csn) && ext_oen && ext_wen, "R11 ack one cycle, bus idle",
        {ack, ext_csn, ext_oen, ext_wen}, {1'b0, 4'hF, 1'b1, 1'b1});
    ntr++;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired after %0d transfers", ntr);
    finish_run();
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk((&ext_csn) && ext_oen && ext_wen && !ack && !ext_dout_en && rd_data == '0,
        "R1 idle during reset", {ext_csn, ext_oen, ext_wen, ack, ext_dout_en},
        {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk((&ext_csn) && ext_oen && ext_wen && !ack && !ext_dout_en && rd_data == '0,
        "R1 idle after reset", {ext_csn, ext_oen, ext_wen, ack, ext_dout_en},
        {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
    for (int w = 0; w < 2; w++)
      for (int pm = 0; pm < 2; pm++)
        for (int wr = 0; wr < 2; wr++)
          for (int a = 0; a < 3; a++)
            for (int c = 0; c < 3; c++)
              for (int x = 0; x < 2; x++)
                for (int h = 0; h < 2; h++)
                  for (int q = 0; q < 3; q++)
                    for (int p = 0; p < 2; p++) begin
                      run(n % 4, 8'(n * 29), wr[0], 16'(n * 40503) ^ 16'h5AA5,
                          a, c, x * 2, h, q, p * 2, w[0], pm[0]);
                      n++;
                    end
    // boundaries: largest counts, address wrap, zero page length
    run(2, 8'hFE, 1'b0, 16'h0, 15, 15, 31, 15, 15, 15, 1'b1, 1'b1);
    run(1, 8'hFD, 1'b0, 16'h0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
    run(3, 8'h00, 1'b1, 16'hBEEF, 15, 15, 31, 15, 15, 15, 1'b1, 1'b1);
    run(0, 8'h80, 1'b1, 16'hC3A7, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    run(3, 8'hFF, 1'b0, 16'h0, 1, 0, 31, 0, 1, 1, 1'b1, 1'b0);
    finish_run();
  end
endmodule